// File: doc/BRIEF.md
# Watchdog timer with key-gated restart

This block is a memory-mapped watchdog with a 32-bit register interface. A 32-bit down-counter advances once for each pulse of a 1 MHz enable strobe. At that rate the longest timeout is roughly 4295 seconds. Software keeps the system alive by writing a fixed 16-bit key to a restart register, which copies the reload register into the counter. Any other value written there is ignored.

When the counter runs out while counting is enabled, the block pulses the actions selected in its control register for one clock cycle:
- an interrupt,
- a reset request, together with a 2-bit reset-domain code,
- an external trigger whose polarity is programmable.

It also records the timeout in a sticky status register. That record notes whether the secondary boot source was selected at the moment of expiry, and this flag is brought out as a pin. After the timeout the counter reloads and keeps running.

The behaviour is built around a three-state machine:
- `ST_HALT`: counting is disabled and the count is held.
- `ST_RUN`: the counter decrements on each tick.
- `ST_FIRE`: a single-cycle expiry state that drives the actions and reloads the counter.

The transitions are:
- HALT→RUN when the enable bit is set.
- RUN→HALT when the enable bit is cleared.
- RUN→FIRE on a tick that finds the count at zero, unless a restart key arrives in the same cycle.
- FIRE→RUN if the enable bit is still set.
- FIRE→HALT if the enable bit has been cleared.

Register offsets (byte addresses on a 5-bit address):
- 0x00: live count, read only.
- 0x04: reload value.
- 0x08: restart key.
- 0x0C: control.
- 0x10: timeout status.
- 0x18: external pulse configuration.

Top module: `watchdog_ctl`

## Requirements
- R1: After reset:
  - the reload register and the count both equal the reset reload value, 0x0000FFFF by default;
  - control and status read 0;
  - offset 0x18 reads 0x800000FF;
  - `irq_o`, `rst_req_o` and `ext_o` are 0, and `alt_boot_o` is 0.
- R2: Reads decode the register offsets listed above. Reload at 0x04 reads back what was written. An unmapped offset reads 0. A write to the count offset 0x00 has no effect.
- R3: A write of exactly 0x00004755 to offset 0x08 loads the count from the reload register, visible on the next cycle. A write of any other value there leaves the count unchanged.
- R4: While control bit 0 (enable) is clear, the count holds its value even when ticks arrive. Setting the bit again resumes counting down from the held count.
- R5: While enabled, each `tick_i` pulse lowers the count by one. A tick that finds the count at 0 enters the expiry state, so with count N the actions appear in the cycle after the (N+1)th tick and not before.
- R6: In the expiry cycle the block raises each selected action for exactly one cycle:
  - control bit 1 selects `rst_req_o`;
  - control bit 2 selects `irq_o`;
  - control bit 3 selects the `ext_o` pulse.
  Unselected actions stay idle. The count is then reloaded from the reload register, and counting continues.
- R7: `rst_dom_o` carries control bits 6:5: 0 for the SoC domain, 1 for the full chip, 2 for the CPU only.
- R8: Status bit 0 sets on every expiry. Status bit 1 sets on an expiry while control bit 7 (secondary boot) is set. Both bits stay set until any write to offset 0x10 clears them, and a set in the same cycle wins over the clear. `alt_boot_o` mirrors status bit 1.
- R9: Offset 0x18 behaves as follows:
  - bits 19:0 store the pulse width on every write;
  - a top byte of 0xA5 sets bit 31 and 0x5A clears it;
  - a top byte of 0xA8 sets bit 30 and 0x8A clears it;
  - any other top byte leaves bits 31:30 unchanged.
- R10: When offset 0x18 bit 31 is 1, `ext_o` idles at 0 and pulses to 1. When bit 31 is 0, `ext_o` idles at 1 and pulses to 0.
- R11: Control bits 7:0 are stored and read back, including bit 4 (1 MHz tick source select). Control bits 31:8 read as 0.
- R12: A restart key write in the same cycle as a tick that finds the count at 0 reloads the count and suppresses the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 MHz count enable strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 5 | Register read byte offset |
| rd_data_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Timeout interrupt pulse |
| rst_req_o | output | 1 | Timeout reset request pulse |
| rst_dom_o | output | 2 | Reset domain code for the request |
| ext_o | output | 1 | External trigger, polarity per offset 0x18 bit 31 |
| alt_boot_o | output | 1 | Secondary boot requested by a recorded timeout |

## Verification
The bench aims at the off-by-one at expiry. It steps the count down to zero and checks that no action appears until the following tick. A design that fired on reaching zero would shorten every timeout by one tick.

It also exercises the following cases:
- A wrong restart value and a write to the read-only count offset. A design that loaded on any write would let runaway software feed the watchdog by accident.
- Ticks while disabled. A design that kept counting would make the count drift.
- A restart key landing on the very tick of expiry. A design with the wrong priority would reset a healthy system.
- Clearing the status register, and the magic top-byte writes. These catch a status that is not sticky, and polarity or drive bits that follow arbitrary writes.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    // register byte offsets (software visible, so fixed)
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_KICK   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PULSE  = 5'h18;

    // control field positions
    localparam int B_EN      = 0;
    localparam int B_RST     = 1;
    localparam int B_IRQ     = 2;
    localparam int B_EXT     = 3;
    localparam int B_TICKSEL = 4;
    localparam int B_DOM_LO  = 5;
    localparam int B_DOM_HI  = 6;
    localparam int B_ALT     = 7;
    localparam int CTRL_W    = 8;

    // status field positions
    localparam int S_TIMEOUT = 0;
    localparam int S_ALT     = 1;
    localparam int STAT_W    = 2;

    localparam logic [31:0] KICK_KEY = 32'h0000_4755;

    // top-byte keys of the pulse configuration register
    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter int               PW_W       = 20,
    parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF,
    parameter logic [PW_W-1:0]  PW_RST     = 20'h000FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [PW_W-1:0]   pw_o,
    output logic              pol_hi_o,
    output logic              push_pull_o,
    output logic              kick_o,
    output logic              stat_clr_o
);

    logic [7:0] top_byte;
    logic       hit_reload;
    logic       hit_ctrl;
    logic       hit_pulse;
    logic       unused_wr_bits;

    assign top_byte       = wr_data_i[31:24];
    assign unused_wr_bits = ^wr_data_i;

    always_comb begin
        hit_reload = wr_en_i && (wr_addr_i == OFS_RELOAD);
        hit_ctrl   = wr_en_i && (wr_addr_i == OFS_CTRL);
        hit_pulse  = wr_en_i && (wr_addr_i == OFS_PULSE);
        kick_o     = wr_en_i && (wr_addr_i == OFS_KICK) && (wr_data_i == KICK_KEY);
        stat_clr_o = wr_en_i && (wr_addr_i == OFS_STAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_o <= RELOAD_RST;
            ctrl_o   <= '0;
        end else begin
            if (hit_reload) reload_o <= wr_data_i[CNT_W-1:0];
            if (hit_ctrl)   ctrl_o   <= wr_data_i[CTRL_W-1:0];
        end
    end

    // pulse configuration: width always written, mode bits only by key
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_o        <= PW_RST;
            pol_hi_o    <= 1'b1;
            push_pull_o <= 1'b0;
        end else if (hit_pulse) begin
            pw_o <= wr_data_i[PW_W-1:0];
            if (top_byte == KEY_POL_HIGH)     pol_hi_o <= 1'b1;
            else if (top_byte == KEY_POL_LOW) pol_hi_o <= 1'b0;
            if (top_byte == KEY_DRV_PP)       push_pull_o <= 1'b1;
            else if (top_byte == KEY_DRV_OD)  push_pull_o <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_pkg::*;
#(
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] CNT_RST = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_en_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output wd_state_e        state_o,
    output logic             fire_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    wd_state_e state_q;
    wd_state_e state_d;
    logic [CNT_W-1:0] cnt_q;
    logic expire;

    assign expire = run_en_i && tick_i && !kick_i && (cnt_q == CNT_ZERO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en_i) state_d = ST_RUN;
            ST_RUN: begin
                if (!run_en_i)   state_d = ST_HALT;
                else if (expire) state_d = ST_FIRE;
            end
            ST_FIRE: state_d = run_en_i ? ST_RUN : ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else if (kick_i || (state_q == ST_FIRE)) begin
            cnt_q <= reload_i;
        end else if ((state_q == ST_RUN) && run_en_i && tick_i && (cnt_q != CNT_ZERO)) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign cnt_o   = cnt_q;
    assign state_o = state_q;
    assign fire_o  = (state_q == ST_FIRE);

endmodule

// File: rtl/wdt_status.sv
`timescale 1ns/1ps
module wdt_status
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              alt_sel_i,
    input  logic              clr_i,
    output logic [STAT_W-1:0] stat_o
);

    logic [STAT_W-1:0] base;
    logic [STAT_W-1:0] set_bits;

    always_comb begin
        base                = clr_i ? '0 : stat_o;
        set_bits            = '0;
        set_bits[S_TIMEOUT] = fire_i;
        set_bits[S_ALT]     = fire_i && alt_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= base | set_bits;
    end

endmodule

// File: rtl/watchdog_ctl.sv
`timescale 1ns/1ps
module watchdog_ctl
    import wdt_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter int               PW_W       = 20,
    parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF,
    parameter logic [PW_W-1:0]  PW_RST     = 20'h000FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [4:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [4:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        irq_o,
    output logic        rst_req_o,
    output logic [1:0]  rst_dom_o,
    output logic        ext_o,
    output logic        alt_boot_o
);

    logic [CNT_W-1:0]  reload_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [PW_W-1:0]   pw_q;
    logic              pol_hi_q;
    logic              push_pull_q;
    logic              kick;
    logic              stat_clr;
    logic [CNT_W-1:0]  cnt_q;
    wd_state_e         state_q;
    logic              fire;
    logic [STAT_W-1:0] stat_q;

    wdt_regs #(
        .CNT_W(CNT_W), .PW_W(PW_W), .RELOAD_RST(RELOAD_RST), .PW_RST(PW_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .reload_o(reload_q), .ctrl_o(ctrl_q), .pw_o(pw_q),
        .pol_hi_o(pol_hi_q), .push_pull_o(push_pull_q),
        .kick_o(kick), .stat_clr_o(stat_clr)
    );

    wdt_core #(
        .CNT_W(CNT_W), .CNT_RST(RELOAD_RST)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick_i), .run_en_i(ctrl_q[B_EN]), .kick_i(kick),
        .reload_i(reload_q), .cnt_o(cnt_q), .state_o(state_q), .fire_o(fire)
    );

    wdt_status u_status (
        .clk(clk), .rst_n(rst_n),
        .fire_i(fire), .alt_sel_i(ctrl_q[B_ALT]), .clr_i(stat_clr),
        .stat_o(stat_q)
    );

    // output process: actions driven from the expiry state
    always_comb begin
        irq_o      = fire && ctrl_q[B_IRQ];
        rst_req_o  = fire && ctrl_q[B_RST];
        rst_dom_o  = ctrl_q[B_DOM_HI:B_DOM_LO];
        ext_o      = (fire && ctrl_q[B_EXT]) ^ !pol_hi_q;
        alt_boot_o = stat_q[S_ALT];
    end

    // read decode
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            OFS_COUNT:  rd_data_o[CNT_W-1:0]  = cnt_q;
            OFS_RELOAD: rd_data_o[CNT_W-1:0]  = reload_q;
            OFS_CTRL:   rd_data_o[CTRL_W-1:0] = ctrl_q;
            OFS_STAT:   rd_data_o[STAT_W-1:0] = stat_q;
            OFS_PULSE: begin
                rd_data_o[31]       = pol_hi_q;
                rd_data_o[30]       = push_pull_q;
                rd_data_o[PW_W-1:0] = pw_q;
            end
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/watchdog_ctl_chk.sv
`timescale 1ns/1ps
module watchdog_ctl_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [4:0]        wr_addr_i,
    input logic [31:0]       wr_data_i,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [STAT_W-1:0] stat_q,
    input wd_state_e         state_q,
    input logic              irq_o,
    input logic              rst_req_o
);

    logic kick_seen;
    logic stat_wr_seen;
    assign kick_seen    = wr_en_i && (wr_addr_i == OFS_KICK) && (wr_data_i == KICK_KEY);
    assign stat_wr_seen = wr_en_i && (wr_addr_i == OFS_STAT);

    assert_kick_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kick_seen |=> (cnt_q == $past(reload_q)));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[B_EN] && !kick_seen && state_q != ST_FIRE) |=> $stable(cnt_q));

    assert_never_counts_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!kick_seen && state_q != ST_FIRE) |=> (cnt_q <= $past(cnt_q)));

    assert_fire_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE) |=> (state_q != ST_FIRE));

    assert_reload_after_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || rst_req_o) |=> (cnt_q == $past(reload_q)));

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[S_TIMEOUT] && !stat_wr_seen) |=> stat_q[S_TIMEOUT]);

endmodule

bind watchdog_ctl watchdog_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cnt_q(cnt_q), .reload_q(reload_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .state_q(state_q), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/test_watchdog_ctl.sv
`timescale 1ns/1ps
module test_watchdog_ctl;

    localparam logic [4:0] A_CNT = 5'h00, A_REL = 5'h04, A_KICK = 5'h08,
                           A_CTRL = 5'h0C, A_STAT = 5'h10, A_PULSE = 5'h18;
    localparam int NVEC = 9;
    // {addr, write data, expected readback}
    localparam logic [68:0] VEC [NVEC] = '{
        {A_REL,   32'h0000_1234, 32'h0000_1234},
        {A_CTRL,  32'hFFFF_FF50, 32'h0000_0050},
        {A_CTRL,  32'h0000_0000, 32'h0000_0000},
        {A_PULSE, 32'h5A00_0010, 32'h0000_0010},
        {A_PULSE, 32'hA800_0020, 32'h4000_0020},
        {A_PULSE, 32'h1200_0030, 32'h4000_0030},
        {A_PULSE, 32'hA500_0040, 32'hC000_0040},
        {A_PULSE, 32'h8A0F_FFFF, 32'h800F_FFFF},
        {5'h14,   32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [4:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o, rst_req_o, ext_o, alt_boot_o;
    logic [1:0]  rst_dom_o;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    watchdog_ctl i_watchdog_ctl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o), .rst_req_o(rst_req_o), .rst_dom_o(rst_dom_o),
        .ext_o(ext_o), .alt_boot_o(alt_boot_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic outs(input string tag, input logic i, input logic r, input logic e);
        chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, i});
        chk({tag, " rst_req"}, {31'b0, rst_req_o}, {31'b0, r});
        chk({tag, " ext"}, {31'b0, ext_o}, {31'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_REL, rv);   chk("R1 reload", rv, 32'h0000_FFFF);
        rd(A_CNT, rv);   chk("R1 count", rv, 32'h0000_FFFF);
        rd(A_CTRL, rv);  chk("R1 ctrl", rv, 32'h0);
        rd(A_STAT, rv);  chk("R1 status", rv, 32'h0);
        rd(A_PULSE, rv); chk("R1 pulse cfg", rv, 32'h8000_00FF);
        outs("R1", 1'b0, 1'b0, 1'b0);
        chk("R1 alt_boot", {31'b0, alt_boot_o}, 32'h0);

        // table walk: R2 R9 R11 register behaviour
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], rv);
            chk($sformatf("R2/R9/R11 vector %0d", i), rv, VEC[i][31:0]);
        end

        // R3 wrong key ignored, correct key loads
        wr(A_REL, 32'd10);
        wr(A_KICK, 32'h0000_4756);
        rd(A_CNT, rv); chk("R3 wrong key", rv, 32'h0000_FFFF);
        wr(A_KICK, 32'h0001_4755);
        rd(A_CNT, rv); chk("R3 wrong upper bits", rv, 32'h0000_FFFF);
        wr(A_KICK, 32'h0000_4755);
        rd(A_CNT, rv); chk("R3 key loads", rv, 32'd10);

        // R2 count offset read only
        wr(A_CNT, 32'd5);
        rd(A_CNT, rv); chk("R2 count write ignored", rv, 32'd10);

        // R4 hold while disabled, resume
        ticks(3);
        rd(A_CNT, rv); chk("R4 hold disabled", rv, 32'd10);
        wr(A_CTRL, 32'h11);
        @(negedge clk);
        ticks(3);
        rd(A_CNT, rv); chk("R5 decrement", rv, 32'd7);
        wr(A_CTRL, 32'h10);
        ticks(2);
        rd(A_CNT, rv); chk("R4 hold after disable", rv, 32'd7);
        wr(A_CTRL, 32'h11);
        @(negedge clk);
        ticks(2);
        rd(A_CNT, rv); chk("R4 resume from held", rv, 32'd5);

        // R5 R6 expiry with no actions selected
        ticks(5);
        rd(A_CNT, rv); chk("R5 reached zero", rv, 32'd0);
        ticks(1);
        outs("R6 unselected", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rd(A_CNT, rv);  chk("R6 reload after expiry", rv, 32'd10);
        rd(A_STAT, rv); chk("R8 timeout recorded", rv, 32'h1);

        // all actions, domain 2, secondary boot
        wr(A_CTRL, 32'hDF);
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); chk("R8 clear by write", rv, 32'h0);
        wr(A_KICK, 32'h0000_4755);
        ticks(10);
        outs("R5 no action at zero", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs("R6 all actions", 1'b1, 1'b1, 1'b1);
        chk("R7 domain cpu", {30'b0, rst_dom_o}, 32'd2);
        @(negedge clk);
        outs("R6 single cycle", 1'b0, 1'b0, 1'b0);
        rd(A_CNT, rv);  chk("R6 reloaded", rv, 32'd10);
        rd(A_STAT, rv); chk("R8 alt boot status", rv, 32'h3);
        chk("R8 alt_boot pin", {31'b0, alt_boot_o}, 32'h1);
        ticks(1);
        rd(A_CNT, rv);  chk("R6 keeps running", rv, 32'd9);

        // R12 key on expiry tick wins
        ticks(9);
        wr_en_i = 1'b1; wr_addr_i = A_KICK; wr_data_i = 32'h0000_4755; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        outs("R12 expiry suppressed", 1'b0, 1'b0, 1'b0);
        rd(A_CNT, rv); chk("R12 reloaded", rv, 32'd10);

        // R8 sticky, then clear
        wr(A_REL, 32'd10);
        rd(A_STAT, rv); chk("R8 sticky", rv, 32'h3);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, rv); chk("R8 cleared", rv, 32'h0);
        chk("R8 alt_boot cleared", {31'b0, alt_boot_o}, 32'h0);

        // R10 active-low external trigger
        wr(A_PULSE, 32'h5A00_00FF);
        chk("R10 idle high", {31'b0, ext_o}, 32'h1);
        ticks(11);
        chk("R10 pulse low", {31'b0, ext_o}, 32'h0);
        chk("R10 irq with pulse", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R10 back idle", {31'b0, ext_o}, 32'h1);

        // R7 domain full chip, no secondary boot
        wr(A_STAT, 32'h0);
        wr(A_CTRL, 32'h3F);
        wr(A_KICK, 32'h0000_4755);
        ticks(11);
        chk("R7 domain full", {30'b0, rst_dom_o}, 32'd1);
        chk("R7 reset request", {31'b0, rst_req_o}, 32'h1);
        @(negedge clk);
        rd(A_STAT, rv); chk("R8 no alt without bit7", rv, 32'h1);
        rd(A_CTRL, rv); chk("R11 ctrl readback", rv, 32'h3F);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule